// File: doc/BRIEF.md
# Cache Cluster Power-Up Sequencer

This block brings the shared second-level cache of a processor cluster, together with its snoop-control arrays, from cold to powered. One pulse on `start` launches a fixed, timed series of steps. The steps set a 32-bit power-control word, raise and later drop a debug-preset override, turn on the cluster clock branch, and finally pass clock gating to hardware. The waits between steps are counted in clock cycles, derived from the `CLK_MHZ` parameter: three short waits of 2 µs each and one long settling wait of 54 µs.

The block samples the headswitch status input in the single cycle where `start` is accepted. If that input already reports the cluster as powered, the block drives nothing new and only reports completion. Otherwise `busy` stays high from the first step until the last one. `done` pulses in the cycle the last step appears. All outputs are registers, so whatever logic drives the power domain can use them directly.

Top module: `l2pwr_upseq`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, the control word, override, clock enable, hardware-control, busy and done outputs are all zero.
- R2: A start accepted while hs_status is 1 makes done high for exactly the next cycle, keeps busy low, and leaves the control word, override and both clock outputs unchanged.
- R3: A start accepted while hs_status is 0 gives, in the next cycle, the control word 0x0010D700. That word has bit 8 (headswitch clamp), bit 9 (headswitch enable), bit 10 (headswitch reset), bit 12 (system reset), bit 14 (snoop array clamp) and bit 15 (cache array clamp) set, and a headswitch count of 16 in bits 27:16. In the same cycle the override is 1, busy is 1, and both clock outputs are 0.
- R4: SHORT = 2*CLK_MHZ cycles after the first step, bits 14 and 15 clear (word 0x00101700). One cycle later, bits 0 and 1, the array headswitches, set (word 0x00101703).
- R5: SHORT cycles after the array headswitches turn on, the clock-branch enable goes to 1 and bit 8 clears (word 0x00101603), both in the same cycle.
- R6: SHORT cycles after that, the override drops to 0 and bits 10 and 12 clear (word 0x00100203), both in the same cycle.
- R7: LONG = 54*CLK_MHZ cycles after that, bit 28, the supply-on request, sets (word 0x10100203). In the same cycle hardware-control goes to 1, busy goes to 0, and done is 1 for that one cycle.
- R8: A start pulse while busy is high is ignored: no step moves in time and no output changes.
- R9: hs_status is ignored at every time except the cycle in which start is accepted.
- R10: After completion, all outputs hold their values until the next accepted start, and done stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to run the power-up series |
| hs_status | input | 1 | Headswitch already-on indication |
| ctrl_word | output | 32 | Power-control word |
| dbg_override | output | 1 | Debug-preset override |
| clk_branch_en | output | 1 | Cluster clock branch enable |
| clk_branch_hw | output | 1 | Clock branch under hardware control |
| busy | output | 1 | Series in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong state or a wrong wait count shows up at the ports as a control word that changes one or more cycles too early or too late. It appears at the first step boundary after the fault, at most one long wait (54*CLK_MHZ cycles) later. The bench compares every output in every cycle of each run, so an error of a single cycle shows up. A fault on the skip path or a restart during busy shows up at once, as a done or busy that does not match, or as a control word that does not match.

// File: rtl/l2pwr_pkg.sv
package l2pwr_pkg;

  // Control-word bit positions (consumed by the power domain)
  localparam int B_ARR_HS    = 0;
  localparam int B_SCU_HS    = 1;
  localparam int B_RST_DIS   = 2;
  localparam int B_HS_CLAMP  = 8;
  localparam int B_HS_EN     = 9;
  localparam int B_HS_RST    = 10;
  localparam int B_SLEEP     = 11;
  localparam int B_SYS_RST   = 12;
  localparam int B_RET       = 13;
  localparam int B_SCU_CLAMP = 14;
  localparam int B_ARR_CLAMP = 15;
  localparam int B_CNT_LSB   = 16;
  localparam int CNT_W       = 12;
  localparam int B_SUPPLY    = 28;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_A,
    ST_ARR_ON,
    ST_WAIT_B,
    ST_WAIT_C,
    ST_WAIT_D
  } seq_state_t;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_INIT,
    ACT_UNCLAMP,
    ACT_ARR_ON,
    ACT_CLK,
    ACT_RST,
    ACT_FINAL,
    ACT_SKIP
  } seq_act_t;

endpackage

// File: rtl/l2pwr_timer.sv
module l2pwr_timer #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] value,
  output logic          zero
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= value;
    end else if (cnt != '0) begin
      cnt <= cnt - TW'(1);
    end
  end

  assign zero = (cnt == '0);

  // R4: an unloaded nonzero count moves down by exactly one per cycle
  a_r4_timer_steps: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - TW'(1)));

endmodule

// File: rtl/l2pwr_fsm.sv
module l2pwr_fsm
  import l2pwr_pkg::*;
#(
  parameter int SHORT_CYC = 100,
  parameter int LONG_CYC  = 2700,
  parameter int TW        = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          hs_status,
  input  logic          tmr_zero,
  output seq_act_t      act,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_value
);

  localparam logic [TW-1:0] SHORT_M1 = TW'(SHORT_CYC - 1);
  localparam logic [TW-1:0] LONG_M1  = TW'(LONG_CYC - 1);

  seq_state_t state, nxt;

  always_comb begin
    nxt       = state;
    act       = ACT_NONE;
    tmr_load  = 1'b0;
    tmr_value = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          if (hs_status) begin
            act = ACT_SKIP;
          end else begin
            act       = ACT_INIT;
            nxt       = ST_WAIT_A;
            tmr_load  = 1'b1;
            tmr_value = SHORT_M1;
          end
        end
      end
      ST_WAIT_A: begin
        if (tmr_zero) begin
          act = ACT_UNCLAMP;
          nxt = ST_ARR_ON;
        end
      end
      ST_ARR_ON: begin
        act       = ACT_ARR_ON;
        nxt       = ST_WAIT_B;
        tmr_load  = 1'b1;
        tmr_value = SHORT_M1;
      end
      ST_WAIT_B: begin
        if (tmr_zero) begin
          act       = ACT_CLK;
          nxt       = ST_WAIT_C;
          tmr_load  = 1'b1;
          tmr_value = SHORT_M1;
        end
      end
      ST_WAIT_C: begin
        if (tmr_zero) begin
          act       = ACT_RST;
          nxt       = ST_WAIT_D;
          tmr_load  = 1'b1;
          tmr_value = LONG_M1;
        end
      end
      ST_WAIT_D: begin
        if (tmr_zero) begin
          act = ACT_FINAL;
          nxt = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  // R8: the long wait is not cut short while the timer is still running
  a_r8_wait_holds: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT_D && !tmr_zero) |=> (state == ST_WAIT_D));

endmodule

// File: rtl/l2pwr_drive.sv
module l2pwr_drive
  import l2pwr_pkg::*;
#(
  parameter int HS_CNT = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  seq_act_t    act,
  output logic [31:0] ctrl_word,
  output logic        dbg_override,
  output logic        clk_branch_en,
  output logic        clk_branch_hw,
  output logic        busy,
  output logic        done
);

  localparam logic [31:0] CNT_FIELD = (32'(HS_CNT) & ((32'(1) << CNT_W) - 32'(1))) << B_CNT_LSB;
  localparam logic [31:0] INIT_WORD = (32'(1) << B_HS_CLAMP) | (32'(1) << B_HS_EN)
                                    | (32'(1) << B_HS_RST)   | (32'(1) << B_SYS_RST)
                                    | (32'(1) << B_SCU_CLAMP) | (32'(1) << B_ARR_CLAMP)
                                    | CNT_FIELD;
  localparam logic [31:0] M_CLAMPS  = (32'(1) << B_SCU_CLAMP) | (32'(1) << B_ARR_CLAMP);
  localparam logic [31:0] M_ARRAYS  = (32'(1) << B_ARR_HS) | (32'(1) << B_SCU_HS);
  localparam logic [31:0] M_RESETS  = (32'(1) << B_HS_RST) | (32'(1) << B_SYS_RST);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_word     <= '0;
      dbg_override  <= 1'b0;
      clk_branch_en <= 1'b0;
      clk_branch_hw <= 1'b0;
      busy          <= 1'b0;
      done          <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (act)
        ACT_INIT: begin
          ctrl_word     <= INIT_WORD;
          dbg_override  <= 1'b1;
          clk_branch_en <= 1'b0;
          clk_branch_hw <= 1'b0;
          busy          <= 1'b1;
        end
        ACT_UNCLAMP: ctrl_word <= ctrl_word & ~M_CLAMPS;
        ACT_ARR_ON:  ctrl_word <= ctrl_word | M_ARRAYS;
        ACT_CLK: begin
          clk_branch_en <= 1'b1;
          ctrl_word     <= ctrl_word & ~(32'(1) << B_HS_CLAMP);
        end
        ACT_RST: begin
          dbg_override <= 1'b0;
          ctrl_word    <= ctrl_word & ~M_RESETS;
        end
        ACT_FINAL: begin
          ctrl_word     <= ctrl_word | (32'(1) << B_SUPPLY);
          clk_branch_hw <= 1'b1;
          busy          <= 1'b0;
          done          <= 1'b1;
        end
        ACT_SKIP: done <= 1'b1;
        default: ;
      endcase
    end
  end

  // R2: the skip path leaves the control outputs untouched
  a_r2_skip_holds: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_SKIP) |=> ($stable(ctrl_word) && $stable(dbg_override)
                           && $stable(clk_branch_en) && $stable(clk_branch_hw)));
  // R5: the headswitch clamp is only open once the clock branch runs
  a_r5_clamp_after_clk: assert property (@(posedge clk) disable iff (rst)
    (busy && !ctrl_word[B_HS_CLAMP]) |-> clk_branch_en);
  // R6: dropping the override goes with released resets
  a_r6_resets_with_ovr: assert property (@(posedge clk) disable iff (rst)
    (busy && !dbg_override) |-> (!ctrl_word[B_HS_RST] && !ctrl_word[B_SYS_RST]));
  // R7: end of busy is marked by done and hardware clock control
  a_r7_end_marked: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done && clk_branch_hw && ctrl_word[B_SUPPLY]));
  // R10: done is never reported while busy
  a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

endmodule

// File: rtl/l2pwr_upseq.sv
module l2pwr_upseq #(
  parameter int CLK_MHZ  = 50,
  parameter int SHORT_US = 2,
  parameter int LONG_US  = 54,
  parameter int HS_CNT   = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        hs_status,
  output logic [31:0] ctrl_word,
  output logic        dbg_override,
  output logic        clk_branch_en,
  output logic        clk_branch_hw,
  output logic        busy,
  output logic        done
);
  import l2pwr_pkg::*;

  localparam int SHORT_CYC = SHORT_US * CLK_MHZ;
  localparam int LONG_CYC  = LONG_US * CLK_MHZ;
  localparam int MAX_CYC   = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int TW        = $clog2(MAX_CYC + 1) + 1;

  seq_act_t      act;
  logic          tmr_load;
  logic [TW-1:0] tmr_value;
  logic          tmr_zero;

  l2pwr_fsm #(
    .SHORT_CYC(SHORT_CYC),
    .LONG_CYC (LONG_CYC),
    .TW       (TW)
  ) fsm_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .hs_status(hs_status),
    .tmr_zero (tmr_zero),
    .act      (act),
    .tmr_load (tmr_load),
    .tmr_value(tmr_value)
  );

  l2pwr_timer #(.TW(TW)) timer_i (
    .clk  (clk),
    .rst  (rst),
    .load (tmr_load),
    .value(tmr_value),
    .zero (tmr_zero)
  );

  l2pwr_drive #(.HS_CNT(HS_CNT)) drive_i (
    .clk          (clk),
    .rst          (rst),
    .act          (act),
    .ctrl_word    (ctrl_word),
    .dbg_override (dbg_override),
    .clk_branch_en(clk_branch_en),
    .clk_branch_hw(clk_branch_hw),
    .busy         (busy),
    .done         (done)
  );

  // R9: status changes alone never start a run
  a_r9_status_ignored: assert property (@(posedge clk) disable iff (rst)
    (!start && !busy) |=> !busy);

endmodule

// File: tb/l2pwr_upseq_tb_top.sv
`timescale 1ns/1ps
module l2pwr_upseq_tb_top;
  localparam int CLK_MHZ = 50;
  localparam int S  = 2 * CLK_MHZ;
  localparam int L  = 54 * CLK_MHZ;
  localparam int NV = 6;
  localparam int FIN = 3 * S + 1 + L;

  // stimulus/expectation table: offset from acceptance, word, {ovr,clk_en,hw,busy}
  localparam int          EXP_OFF [NV] = '{0, S, S + 1, 2 * S + 1, 3 * S + 1, FIN};
  localparam logic [31:0] EXP_W   [NV] = '{32'h0010D700, 32'h00101700, 32'h00101703,
                                           32'h00101603, 32'h00100203, 32'h10100203};
  localparam logic [3:0]  EXP_F   [NV] = '{4'b1001, 4'b1001, 4'b1001, 4'b1101, 4'b0101, 4'b0110};
  localparam string       EXP_R   [NV] = '{"R3", "R4", "R4", "R5", "R6", "R7"};

  logic clk = 1'b0;
  logic rst, start, hs_status;
  logic [31:0] ctrl_word;
  logic dbg_override, clk_branch_en, clk_branch_hw, busy, done;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  l2pwr_upseq #(.CLK_MHZ(CLK_MHZ)) dut_i (
    .clk(clk), .rst(rst), .start(start), .hs_status(hs_status),
    .ctrl_word(ctrl_word), .dbg_override(dbg_override),
    .clk_branch_en(clk_branch_en), .clk_branch_hw(clk_branch_hw),
    .busy(busy), .done(done)
  );

  function automatic logic [36:0] snap();
    return {ctrl_word, dbg_override, clk_branch_en, clk_branch_hw, busy, done};
  endfunction

  task automatic chk(input string req, input logic [36:0] act_v, input logic [36:0] exp_v);
    n_chk++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act_v, exp_v, $time);
    end
  endtask

  // one full run; poke adds a start during busy (R8) and raises status mid-run (R9)
  task automatic run_seq(input bit poke);
    @(negedge clk); start = 1'b1; hs_status = 1'b0;
    @(negedge clk); start = 1'b0;
    for (int t = 0; t <= FIN + 2; t++) begin
      int idx = 0;
      for (int i = 0; i < NV; i++) if (EXP_OFF[i] <= t) idx = i;
      chk(poke ? {"R8/R9/", EXP_R[idx]} : EXP_R[idx], snap(),
          {EXP_W[idx], EXP_F[idx], 1'(t == FIN)});
      if (poke && t == 50) begin start = 1'b1; hs_status = 1'b1; end
      if (poke && t == 51) start = 1'b0;
      @(negedge clk);
    end
    hs_status = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; hs_status = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", snap(), 37'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", snap(), 37'd0);

    // R2: skip from cold
    start = 1'b1; hs_status = 1'b1;
    @(negedge clk); start = 1'b0; hs_status = 1'b0;
    chk("R2", snap(), {32'd0, 4'b0000, 1'b1});
    @(negedge clk);
    chk("R2", snap(), 37'd0);

    // R9: status alone starts nothing
    hs_status = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9", snap(), 37'd0);
    hs_status = 1'b0;

    run_seq(1'b0);

    // R10: outputs hold after completion
    repeat (20) @(negedge clk);
    chk("R10", snap(), {EXP_W[NV-1], EXP_F[NV-1], 1'b0});

    // R2: skip after a completed run keeps everything
    start = 1'b1; hs_status = 1'b1;
    @(negedge clk); start = 1'b0; hs_status = 1'b0;
    chk("R2", snap(), {EXP_W[NV-1], EXP_F[NV-1], 1'b1});
    @(negedge clk);
    chk("R2", snap(), {EXP_W[NV-1], EXP_F[NV-1], 1'b0});

    run_seq(1'b1);
    repeat (5) @(negedge clk);
    chk("R10", snap(), {EXP_W[NV-1], EXP_F[NV-1], 1'b0});

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule